// File: doc/BRIEF.md
# TDM Bit Clock and Frame Sync Generator

This block produces the timing skeleton of a serial time-division-multiplexed voice port. As timing master, it divides the system clock into a bit clock with a 50% duty cycle. It divides that bit clock into frames and shapes a frame sync pulse whose width and active level are programmable. Two independent delay counters mark where timeslot 0 begins for the receive path and for the transmit path. Each direction can therefore start its data at its own bit offset after the sync.

All logic runs on the system clock. The block creates no derived clock: every bit-period event is gated by a one-cycle enable strobe that downstream shift logic can use directly. As timing slave, the internal dividers are bypassed. Bit clock and frame sync arrive from outside, pass through a two-flop synchronizer, and their rising edges produce the same enable strobe and frame start.

Top module: `tdm_sync_gen`

## Requirements
- R1: In master mode with divider value N, `bclk_out` has a period of 2×(N+1) system clocks and stays high for N+1 of them.
- R2: During reset and after reset, until the first bit clock rising edge, `bclk_out` is 0, `fs_out` sits at its inactive level (equal to `fs_invert`), and both timeslot strobes are 0.
- R3: In master mode a frame holds `frame_len`+1 bit clocks, so successive frame sync leading edges are `frame_len`+1 bit clock rises apart.
- R4: In master mode the frame sync is active from bit 0 through bit `fs_width` of each frame, which gives `fs_width`+1 bit clocks. Bit 0 starts at the first bit clock rise after reset and again after bit `frame_len`. The sync is inactive for the remaining bits.
- R5: `fs_invert`=0 makes the active sync level high. `fs_invert`=1 makes it low.
- R6: `rx_ts0` is high for exactly one bit clock period, during bit `rx_offset` of each frame. An offset of 0 makes it coincide with the first bit of the sync.
- R7: `tx_ts0` behaves like `rx_ts0` but uses `tx_offset`, independently of the receive offset.
- R8: An offset larger than `frame_len` never produces a timeslot strobe, because each frame start reloads the counter.
- R9: In slave mode (`master`=0), every rising edge of `ext_bclk` gives a one-system-clock `bit_stb` pulse two clocks after the edge is first sampled. During slave mode `bclk_out` is held at 0 and `fs_out` at its inactive level.
- R10: In slave mode, a bit clock rise at which the synchronized `ext_fs` is active, after being inactive at the previous rise, starts a frame. Both timeslot strobes then follow their offsets counted from that rise.
- R11: In master mode `bit_stb` is high for the single system clock that immediately precedes each rising edge of `bclk_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1: internal dividers generate timing; 0: external timing is used |
| bclk_div | input | 8 | Bit clock divider value N |
| frame_len | input | 10 | Bit clocks per frame minus one |
| fs_width | input | 10 | Frame sync active width in bit clocks minus one |
| fs_invert | input | 1 | Selects an active-low frame sync |
| rx_offset | input | 10 | Bit clocks from frame start to receive timeslot 0 |
| tx_offset | input | 10 | Bit clocks from frame start to transmit timeslot 0 |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fs | input | 1 | External frame sync, polarity per `fs_invert` (slave mode) |
| bclk_out | output | 1 | Generated bit clock |
| fs_out | output | 1 | Generated frame sync |
| bit_stb | output | 1 | One-cycle enable for each bit clock rise |
| rx_ts0 | output | 1 | Receive timeslot 0 start, one bit period long |
| tx_ts0 | output | 1 | Transmit timeslot 0 start, one bit period long |

## Verification
In master mode `bclk_out`, `fs_out` and both timeslot strobes change at the same clock edge, the one that raises the bit clock, and `bit_stb` is high during the cycle before it. The bench samples on falling clock edges. It finds each rise of `bclk_out` on its own and compares every sync and strobe value with a bit index it keeps itself. In slave mode an external edge applied at a falling edge shows up as `bit_stb` after the second rising clock edge and moves the strobes at the third. The bench checks the pulse at the falling edge after the second rising edge, and the strobes and the pulse's end one falling edge later.

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen #(
  parameter int DIV_W = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic [DIV_W-1:0] bclk_div,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] fs_width,
  input  logic             fs_invert,
  input  logic [LEN_W-1:0] rx_offset,
  input  logic [LEN_W-1:0] tx_offset,
  input  logic             ext_bclk,
  input  logic             ext_fs,
  output logic             bclk_out,
  output logic             fs_out,
  output logic             bit_stb,
  output logic             rx_ts0,
  output logic             tx_ts0
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [DIV_W-1:0] div_cnt;
  logic             bclk_q;
  logic [2:0]       bsync;
  logic [1:0]       fsync;
  logic             ext_rise, ext_fs_act;
  logic             started, fs_prev, frame_start;
  logic [LEN_W-1:0] bit_cnt;
  logic [LEN_W-1:0] ofs [2];
  logic [LEN_W-1:0] dly [2];
  logic [1:0]       armed, ts;

  // external timing: two-flop synchronizer, then rising edge detect
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsync <= '0;
      fsync <= '0;
    end else begin
      bsync <= {bsync[1:0], ext_bclk};
      fsync <= {fsync[0], ext_fs};
    end
  end

  assign ext_rise   = bsync[1] & ~bsync[2];
  assign ext_fs_act = fsync[1] ^ fs_invert;

  // bit clock divider
  always_ff @(posedge clk) begin
    if (!rst_n || !master) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (div_cnt >= bclk_div) begin
      div_cnt <= '0;
      bclk_q  <= ~bclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign bit_stb = master ? ((div_cnt >= bclk_div) && !bclk_q) : ext_rise;

  assign frame_start = bit_stb &&
    (master ? (!started || bit_cnt >= frame_len) : (ext_fs_act && !fs_prev));

  // bit position within the frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      fs_prev <= 1'b0;
      bit_cnt <= '0;
    end else if (bit_stb) begin
      fs_prev <= ext_fs_act;
      if (frame_start) begin
        started <= 1'b1;
        bit_cnt <= '0;
      end else if (started) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign bclk_out = master & bclk_q;
  assign fs_out   = (master && started && bit_cnt <= fs_width) ^ fs_invert;

  // timeslot-0 delay counters: index 0 receive, index 1 transmit
  assign ofs[0] = rx_offset;
  assign ofs[1] = tx_offset;

  for (genvar g = 0; g < 2; g++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dly[g]   <= '0;
        armed[g] <= 1'b0;
        ts[g]    <= 1'b0;
      end else if (bit_stb) begin
        if (frame_start) begin
          dly[g]   <= ofs[g];
          armed[g] <= (ofs[g] != '0);
          ts[g]    <= (ofs[g] == '0);
        end else if (armed[g]) begin
          dly[g]   <= dly[g] - ONE;
          armed[g] <= (dly[g] != ONE);
          ts[g]    <= (dly[g] == ONE);
        end else begin
          ts[g]    <= 1'b0;
        end
      end
    end
  end

  assign rx_ts0 = ts[0];
  assign tx_ts0 = ts[1];

  // R6
  rx_ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_stb) |-> $stable(rx_ts0));

  // R7
  tx_ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_stb) |-> $stable(tx_ts0));

  // R4
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $stable(master) && $stable(fs_invert) && $stable(fs_width) && !$past(bit_stb))
      |-> $stable(fs_out));

  // R11
  stb_then_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && bit_stb) |=> (bclk_out || !master));

  // R11
  rise_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $rose(bclk_out)) |-> $past(bit_stb));

endmodule

// File: tb/sim_tdm_sync_gen.sv
module sim_tdm_sync_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master = 1'b1;
  logic [7:0] bclk_div = '0;
  logic [9:0] frame_len = '0, fs_width = '0, rx_offset = '0, tx_offset = '0;
  logic       fs_invert = 1'b0, ext_bclk = 1'b0, ext_fs = 1'b0;
  logic       bclk_out, fs_out, bit_stb, rx_ts0, tx_ts0;

  always #10 clk = ~clk;

  tdm_sync_gen u0 (
    .clk(clk), .rst_n(rst_n), .master(master), .bclk_div(bclk_div),
    .frame_len(frame_len), .fs_width(fs_width), .fs_invert(fs_invert),
    .rx_offset(rx_offset), .tx_offset(tx_offset), .ext_bclk(ext_bclk),
    .ext_fs(ext_fs), .bclk_out(bclk_out), .fs_out(fs_out), .bit_stb(bit_stb),
    .rx_ts0(rx_ts0), .tx_ts0(tx_ts0)
  );

  int n_total = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // master-mode monitor state
  bit mon_on = 0;
  int m_n, m_l, m_w, m_rx, m_tx;
  bit m_inv;
  int cyc, bitn, last_rise, rises_since, rx_hits;
  bit prev_b, first_seen, have_rise, stb_pend, prev_act, seen_lead;
  int err_per, err_stb, err_fs, err_rx, err_tx, err_len;

  always @(negedge clk) begin
    if (mon_on) begin
      bit b, rise, fall, act, efs, erx, etx;
      cyc++;
      b = bclk_out;
      rise = b && !prev_b;
      fall = !b && prev_b;
      if (rise) begin
        if (have_rise && (cyc - last_rise) != 2 * (m_n + 1)) err_per++;
        last_rise = cyc;
        have_rise = 1;
        bitn = !first_seen ? 0 : (bitn == m_l ? 0 : bitn + 1);
        first_seen = 1;
        rises_since++;
      end
      if (fall && (cyc - last_rise) != m_n + 1) err_per++;
      if (stb_pend != rise) err_stb++;
      stb_pend = bit_stb;
      efs = first_seen ? ((bitn <= m_w) ^ m_inv) : m_inv;
      erx = first_seen && (bitn == m_rx);
      etx = first_seen && (bitn == m_tx);
      if (fs_out != efs) err_fs++;
      if (rx_ts0 != erx) err_rx++;
      if (tx_ts0 != etx) err_tx++;
      if (rx_ts0) rx_hits++;
      act = fs_out ^ m_inv;
      if (act && !prev_act) begin
        if (seen_lead && rises_since != m_l + 1) err_len++;
        seen_lead = 1;
        rises_since = 0;
      end
      prev_act = act;
      prev_b = b;
    end
  end

  task automatic do_reset(input bit inv);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R2: state during reset
    check(bclk_out == 1'b0, "R2 bclk in reset", bclk_out, 0);
    check(fs_out == inv, "R2 fs in reset", fs_out, inv);
    check(rx_ts0 == 1'b0 && tx_ts0 == 1'b0, "R2 strobes in reset", {rx_ts0, tx_ts0}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_master(input int n, input int l, input int w, input bit inv,
                            input int rxo, input int txo, input int frames, input string tag);
    master = 1'b1; bclk_div = 8'(n); frame_len = 10'(l); fs_width = 10'(w);
    fs_invert = inv; rx_offset = 10'(rxo); tx_offset = 10'(txo);
    m_n = n; m_l = l; m_w = w; m_inv = inv; m_rx = rxo; m_tx = txo;
    @(negedge clk);
    do_reset(inv);
    #1;
    cyc = 0; bitn = 0; last_rise = 0; rises_since = 0; rx_hits = 0;
    prev_b = 0; first_seen = 0; have_rise = 0; prev_act = 0; seen_lead = 0;
    stb_pend = bit_stb;
    err_per = 0; err_stb = 0; err_fs = 0; err_rx = 0; err_tx = 0; err_len = 0;
    // R2: outputs right after release
    check(bclk_out == 1'b0 && fs_out == inv, "R2 after release", {bclk_out, fs_out}, {1'b0, inv});
    mon_on = 1;
    repeat (frames * (l + 1) * 2 * (n + 1) + 6) @(negedge clk);
    #1 mon_on = 0;
    $display("scenario %s", tag);
    check(have_rise, "R1 bit clock running", have_rise, 1);
    check(err_per == 0, "R1 bit clock period/duty", err_per, 0);
    check(err_stb == 0, "R11 bit_stb before rise", err_stb, 0);
    check(err_fs == 0, inv ? "R5 inverted frame sync" : "R4 frame sync width", err_fs, 0);
    check(err_len == 0, "R3 frame length", err_len, 0);
    check(err_rx == 0, "R6 rx timeslot strobe", err_rx, 0);
    check(err_tx == 0, "R7 tx timeslot strobe", err_tx, 0);
    if (rxo > l) check(rx_hits == 0, "R8 out-of-frame offset", rx_hits, 0);
  endtask

  task automatic run_slave(input int f, input bit inv, input int rxo, input int txo,
                           input int nbits);
    int e_stb = 0, e_idle = 0, e_rx = 0, e_tx = 0;
    master = 1'b0; bclk_div = 8'd0; frame_len = 10'd1023; fs_width = 10'd0;
    fs_invert = inv; rx_offset = 10'(rxo); tx_offset = 10'(txo);
    ext_bclk = 1'b0; ext_fs = inv;
    @(negedge clk);
    do_reset(inv);
    for (int j = 0; j < nbits; j++) begin
      @(negedge clk);
      ext_bclk = 1'b0;
      ext_fs = ((j % f) == 0) ^ inv;
      repeat (3) @(negedge clk);
      @(negedge clk);
      ext_bclk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (bit_stb !== 1'b1) e_stb++;
      @(negedge clk);
      if (bit_stb !== 1'b0) e_stb++;
      if (bclk_out !== 1'b0 || fs_out !== inv) e_idle++;
      if (rx_ts0 !== ((j % f) == rxo)) e_rx++;
      if (tx_ts0 !== ((j % f) == txo)) e_tx++;
    end
    check(e_stb == 0, "R9 slave bit strobe timing", e_stb, 0);
    check(e_idle == 0, "R9 slave outputs idle", e_idle, 0);
    check(e_rx == 0, "R10 slave rx strobe", e_rx, 0);
    check(e_tx == 0, "R10 slave tx strobe", e_tx, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    run_master(1, 7, 0, 1'b0, 0, 3, 3, "A offset zero");
    run_master(3, 15, 2, 1'b1, 5, 15, 3, "B inverted, last bit");
    run_master(0, 4, 1, 1'b0, 9, 1, 4, "C offset past frame");
    run_master(255, 3, 0, 1'b0, 2, 2, 2, "D max divider");
    run_slave(6, 1'b0, 0, 2, 14);
    run_slave(5, 1'b1, 3, 1, 12);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule